// File: doc/BRIEF.md
# Byte-Window Instruction RAM Loader

This block fills a 32-bit-wide instruction memory through a narrow register window. Software writes a word address into two address registers: a full low byte and a high register of which only the bottom bit counts, which gives a 9-bit word address. It sets the load-enable bit in the control register and then writes bytes one after another to a single data window. The loader gathers four bytes into a word, least significant byte first. When the fourth byte arrives it writes the whole word to memory and steps the word address forward by one.

Reads through the same window return the addressed word one byte at a time. They use the same lane order and the same address step after the fourth byte, so firmware can be checked after it is loaded. The control register also holds a sequencer-reset bit, which is passed straight out. A separate combinational fetch port lets the instruction consumer read any stored word.

Top module: `iram_loader`

## Requirements
- R1: After reset, load enable is 0, sequencer reset is 0, the word address is 0 and the byte lane index is 0.
- R2: A control write sets load enable from data bit 0 and sequencer reset from data bit 1. The other data bits have no effect.
- R3: Window bytes fill lanes in ascending order, from bits 7:0 up to bits 31:24. The lane index steps by one on each accepted window access and returns to 0 after lane 3.
- R4: The fourth accepted byte writes the word {byte3, byte2, byte1, byte0} at the current address. The address then increments by one. The first three bytes leave the address unchanged.
- R5: A low-address write loads address bits 7:0 from the data byte. A high-address write loads address bit 8 from data bit 0 and ignores the rest. Either write returns the lane index to 0.
- R6: A window write while load enable is 0 is ignored. Memory, address and lane index all stay unchanged. The load-enable value used is the one held before that cycle.
- R7: The window read data is lane (index) of the word at the current address. A read strobe advances the index and address exactly as a write does. Reads do not depend on load enable.
- R8: The word address wraps from 511 to 0.
- R9: In one cycle, an address-register write takes priority over any window access, and that window access is dropped. A window write takes priority over a window read, and the read is dropped.
- R10: The fetch port returns the stored word at the fetch address combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wdata | input | 8 | Write data shared by all register strobes |
| ctl_we | input | 1 | Control register write strobe |
| addr_lo_we | input | 1 | Low address register write strobe |
| addr_hi_we | input | 1 | High address register write strobe |
| win_we | input | 1 | Data window write strobe |
| win_re | input | 1 | Data window read strobe (advances lane) |
| win_rdata | output | 8 | Current window byte |
| word_addr | output | 9 | Current word address |
| load_en | output | 1 | Load enable control bit |
| seq_rst | output | 1 | Sequencer reset control bit |
| fetch_addr | input | 9 | Instruction fetch address |
| fetch_data | output | 32 | Instruction word at fetch_addr |

## Verification
The loader is driven with streams of distinct bytes, one value per lane. A lane swap or an off-by-one step in the lane index therefore shows up in the assembled word. Words are loaded at consecutive addresses, across the 511-to-0 wrap, and after an address change that lands in the middle of a word. These cases separate a correct increment point from one that moves too early or too late, and show whether the lane index is cleared. Window writes are also given with load enable off, and are then read back through the window. Strobes are issued in the same cycle to expose which access wins.

// File: rtl/iram_loader_pkg.sv
package iram_loader_pkg;
    localparam int CTL_LOAD_BIT = 0;
    localparam int CTL_SRST_BIT = 1;

    typedef enum logic [1:0] {
        ACC_NONE  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_READ  = 2'd2
    } win_acc_e;
endpackage

// File: rtl/iram_loader_ctl.sv
module iram_loader_ctl
    import iram_loader_pkg::*;
#(
    parameter int ADDR_W = 9,
    parameter int BYTE_W = 8,
    parameter int LANES  = 4,
    localparam int IDX_W = $clog2(LANES),
    localparam int HI_W  = ADDR_W - BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BYTE_W-1:0] reg_wdata,
    input  logic              ctl_we,
    input  logic              addr_lo_we,
    input  logic              addr_hi_we,
    input  logic              win_we,
    input  logic              win_re,
    output logic              load_en,
    output logic              seq_rst,
    output logic [ADDR_W-1:0] word_addr,
    output logic [IDX_W-1:0]  lane_idx,
    output win_acc_e          acc
);
    typedef struct packed {
        logic              load_en;
        logic              seq_rst;
        logic [ADDR_W-1:0] addr;
        logic [IDX_W-1:0]  idx;
    } ctl_state_t;

    ctl_state_t st_d, st_q;
    win_acc_e   acc_d;

    always_comb begin
        st_d  = st_q;
        acc_d = ACC_NONE;
        // address writes win; window write wins over read
        if (addr_lo_we || addr_hi_we) begin
            acc_d = ACC_NONE;
        end else if (win_we) begin
            acc_d = st_q.load_en ? ACC_WRITE : ACC_NONE;
        end else if (win_re) begin
            acc_d = ACC_READ;
        end

        if (ctl_we) begin
            st_d.load_en = reg_wdata[CTL_LOAD_BIT];
            st_d.seq_rst = reg_wdata[CTL_SRST_BIT];
        end
        if (addr_lo_we) begin
            st_d.addr[BYTE_W-1:0] = reg_wdata;
            st_d.idx              = '0;
        end
        if (addr_hi_we) begin
            st_d.addr[ADDR_W-1:BYTE_W] = reg_wdata[HI_W-1:0];
            st_d.idx                   = '0;
        end
        if (acc_d != ACC_NONE) begin
            if (st_q.idx == IDX_W'(LANES - 1)) begin
                st_d.idx  = '0;
                st_d.addr = st_q.addr + 1'b1;
            end else begin
                st_d.idx = st_q.idx + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign load_en   = st_q.load_en;
    assign seq_rst   = st_q.seq_rst;
    assign word_addr = st_q.addr;
    assign lane_idx  = st_q.idx;
    assign acc       = acc_d;

    a_r5_idx_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_lo_we || addr_hi_we) |=> (lane_idx == '0));

    a_r6_ignored_write: assert property (@(posedge clk) disable iff (!rst_n)
        (win_we && !load_en && !addr_lo_we && !addr_hi_we)
            |=> ($stable(lane_idx) && $stable(word_addr)));

    a_r3_idx_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (win_re && !win_we && !addr_lo_we && !addr_hi_we && lane_idx == IDX_W'(LANES - 1))
            |=> (lane_idx == '0));

    a_r9_addr_priority: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_lo_we && addr_hi_we)
            |=> (word_addr == {$past(reg_wdata[HI_W-1:0]), $past(reg_wdata)}));
endmodule

// File: rtl/iram_lane_pack.sv
module iram_lane_pack #(
    parameter int BYTE_W = 8,
    parameter int LANES  = 4,
    localparam int IDX_W  = $clog2(LANES),
    localparam int DATA_W = BYTE_W * LANES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  idx,
    input  logic [BYTE_W-1:0] byte_in,
    output logic              word_we,
    output logic [DATA_W-1:0] word_data
);
    logic [LANES-2:0][BYTE_W-1:0] stage_d, stage_q;

    always_comb begin
        stage_d = stage_q;
        for (int l = 0; l < LANES - 1; l++) begin
            if (wr_en && idx == IDX_W'(l)) stage_d[l] = byte_in;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) stage_q <= '0;
        else        stage_q <= stage_d;
    end

    assign word_we = wr_en && (idx == IDX_W'(LANES - 1));

    for (genvar g = 0; g < LANES - 1; g++) begin : g_lane
        assign word_data[g*BYTE_W +: BYTE_W] = stage_q[g];
    end
    assign word_data[DATA_W-1 -: BYTE_W] = byte_in;

    a_r3_lane0_capture: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && idx == '0) |=> (word_data[BYTE_W-1:0] == $past(byte_in)));
endmodule

// File: rtl/iram_word_ram.sv
module iram_word_ram #(
    parameter int ADDR_W = 9,
    parameter int DATA_W = 32,
    localparam int DEPTH = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr_a,
    output logic [DATA_W-1:0] rdata_a,
    input  logic [ADDR_W-1:0] raddr_b,
    output logic [DATA_W-1:0] rdata_b
);
    logic [DATA_W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem_q[waddr] <= wdata;
    end

    assign rdata_a = mem_q[raddr_a];
    assign rdata_b = mem_q[raddr_b];
endmodule

// File: rtl/iram_loader.sv
module iram_loader
    import iram_loader_pkg::*;
#(
    parameter int ADDR_W = 9,
    parameter int BYTE_W = 8,
    parameter int LANES  = 4,
    localparam int IDX_W  = $clog2(LANES),
    localparam int DATA_W = BYTE_W * LANES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BYTE_W-1:0] reg_wdata,
    input  logic              ctl_we,
    input  logic              addr_lo_we,
    input  logic              addr_hi_we,
    input  logic              win_we,
    input  logic              win_re,
    output logic [BYTE_W-1:0] win_rdata,
    output logic [ADDR_W-1:0] word_addr,
    output logic              load_en,
    output logic              seq_rst,
    input  logic [ADDR_W-1:0] fetch_addr,
    output logic [DATA_W-1:0] fetch_data
);
    win_acc_e          acc;
    logic [IDX_W-1:0]  lane_idx;
    logic              ram_we;
    logic [DATA_W-1:0] ram_wdata;
    logic [DATA_W-1:0] win_word;

    iram_loader_ctl #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W), .LANES(LANES)) ctl_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .reg_wdata  (reg_wdata),
        .ctl_we     (ctl_we),
        .addr_lo_we (addr_lo_we),
        .addr_hi_we (addr_hi_we),
        .win_we     (win_we),
        .win_re     (win_re),
        .load_en    (load_en),
        .seq_rst    (seq_rst),
        .word_addr  (word_addr),
        .lane_idx   (lane_idx),
        .acc        (acc)
    );

    iram_lane_pack #(.BYTE_W(BYTE_W), .LANES(LANES)) pack_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (acc == ACC_WRITE),
        .idx       (lane_idx),
        .byte_in   (reg_wdata),
        .word_we   (ram_we),
        .word_data (ram_wdata)
    );

    iram_word_ram #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) ram_i (
        .clk     (clk),
        .we      (ram_we),
        .waddr   (word_addr),
        .wdata   (ram_wdata),
        .raddr_a (word_addr),
        .rdata_a (win_word),
        .raddr_b (fetch_addr),
        .rdata_b (fetch_data)
    );

    assign win_rdata = win_word[lane_idx*BYTE_W +: BYTE_W];

    a_r6_write_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |-> load_en);

    a_r4_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |=> (word_addr == ADDR_W'($past(word_addr) + 1'b1)));

    a_r4_word_stored: assert property (@(posedge clk) disable iff (!rst_n)
        (ram_we && fetch_addr == word_addr) |=> (fetch_data == $past(ram_wdata)));
endmodule

// File: tb/iram_loader_tb_top.sv
`timescale 1ns/1ps
module iram_loader_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  reg_wdata = '0;
    logic        ctl_we = 0, addr_lo_we = 0, addr_hi_we = 0, win_we = 0, win_re = 0;
    logic [7:0]  win_rdata;
    logic [8:0]  word_addr;
    logic        load_en, seq_rst;
    logic [8:0]  fetch_addr = '0;
    logic [31:0] fetch_data;

    always #2.5 clk = ~clk;

    iram_loader dut_i (
        .clk(clk), .rst_n(rst_n), .reg_wdata(reg_wdata), .ctl_we(ctl_we),
        .addr_lo_we(addr_lo_we), .addr_hi_we(addr_hi_we), .win_we(win_we),
        .win_re(win_re), .win_rdata(win_rdata), .word_addr(word_addr),
        .load_en(load_en), .seq_rst(seq_rst), .fetch_addr(fetch_addr),
        .fetch_data(fetch_data)
    );

    // reference model
    logic [31:0] mem_m [512];
    bit          vld_m [512];
    int          addr_m = 0, idx_m = 0;
    logic [7:0]  stage_m [4];
    bit          le_m = 0, sr_m = 0;
    int          checks = 0, errors = 0;
    bit          done = 0;
    int          last_w = -1;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic compare(input string tag);
        chk(word_addr === 9'(addr_m), {tag, " addr"}, word_addr, addr_m);
        chk(load_en === le_m, {tag, " load_en"}, load_en, le_m);
        chk(seq_rst === sr_m, {tag, " seq_rst"}, seq_rst, sr_m);
        if (vld_m[addr_m])
            chk(win_rdata === 8'(mem_m[addr_m] >> (8 * idx_m)), {tag, " rdata"},
                win_rdata, (mem_m[addr_m] >> (8 * idx_m)) & 255);
        if (vld_m[fetch_addr])
            chk(fetch_data === mem_m[fetch_addr], {tag, " R10 fetch"}, fetch_data, mem_m[fetch_addr]);
    endtask

    task automatic step(input bit c, input bit lo, input bit hi, input bit w,
                        input bit r, input logic [7:0] d, input string tag);
        int acc;
        ctl_we = c; addr_lo_we = lo; addr_hi_we = hi; win_we = w; win_re = r; reg_wdata = d;
        @(posedge clk);
        acc = 0;
        if (lo || hi) acc = 0;
        else if (w) acc = le_m ? 1 : 0;
        else if (r) acc = 2;
        if (c) begin le_m = d[0]; sr_m = d[1]; end
        if (lo) begin addr_m = (addr_m & 256) | d; idx_m = 0; end
        if (hi) begin addr_m = (addr_m & 255) | (int'(d[0]) << 8); idx_m = 0; end
        if (acc == 1) begin
            stage_m[idx_m] = d;
            if (idx_m == 3) begin
                mem_m[addr_m] = {stage_m[3], stage_m[2], stage_m[1], stage_m[0]};
                vld_m[addr_m] = 1;
                last_w = addr_m;
            end
        end
        if (acc != 0) begin
            if (idx_m == 3) begin idx_m = 0; addr_m = (addr_m + 1) % 512; end
            else idx_m++;
        end
        @(negedge clk);
        ctl_we = 0; addr_lo_we = 0; addr_hi_we = 0; win_we = 0; win_re = 0;
        if (last_w >= 0) fetch_addr = 9'(last_w);
        compare(tag);
    endtask

    task automatic set_addr(input int a, input string tag);
        step(0, 1, 0, 0, 0, 8'(a), tag);
        step(0, 0, 1, 0, 0, 8'(a >> 8), tag);
    endtask

    task automatic put_word(input logic [31:0] v, input string tag);
        for (int b = 0; b < 4; b++) step(0, 0, 0, 1, 0, v[8*b +: 8], tag);
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual 0x0 expected 0x1");
            $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] lfsr;
        int          a0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk(word_addr === 9'd0, "R1 addr", word_addr, 0);
        chk(load_en === 1'b0, "R1 load_en", load_en, 0);
        chk(seq_rst === 1'b0, "R1 seq_rst", seq_rst, 0);

        // R6 writes ignored while disabled
        put_word(32'hDEADBEEF, "R6");
        chk(word_addr === 9'd0, "R6 addr held", word_addr, 0);

        // R2 control bits
        step(1, 0, 0, 0, 0, 8'hFE, "R2");
        step(1, 0, 0, 0, 0, 8'h01, "R2");
        step(1, 0, 0, 0, 0, 8'h03, "R2");
        step(1, 0, 0, 0, 0, 8'h01, "R2");

        // R3 R4 words at 0..3
        put_word(32'h44332211, "R3");
        put_word(32'h88776655, "R4");
        put_word(32'hCCBBAA99, "R4");
        put_word(32'h0FEDCBA9, "R4");
        chk(word_addr === 9'd4, "R4 addr after four words", word_addr, 4);

        // R5 address registers, mid-word restart
        set_addr(32'h110, "R5");
        step(0, 0, 1, 0, 0, 8'hFE, "R5 hi bit0 only");
        step(0, 0, 0, 1, 0, 8'hA1, "R5");
        step(0, 0, 0, 1, 0, 8'hA2, "R5");
        step(0, 1, 0, 0, 0, 8'h20, "R5 idx clear");
        put_word(32'h5A6B7C8D, "R5");
        step(0, 0, 1, 0, 0, 8'h01, "R5");
        put_word(32'h13579BDF, "R5");

        // R8 wrap
        set_addr(511, "R8");
        put_word(32'hCAFEF00D, "R8");
        chk(word_addr === 9'd0, "R8 wrap", word_addr, 0);

        // R7 reads, also with load disabled
        set_addr(0, "R7");
        for (int i = 0; i < 8; i++) step(0, 0, 0, 0, 1, 8'h00, "R7");
        step(1, 0, 0, 0, 0, 8'h00, "R7");
        set_addr(511, "R7");
        for (int i = 0; i < 6; i++) step(0, 0, 0, 0, 1, 8'h00, "R7 R8");

        // R6 again: disabled writes leave word 1 intact
        set_addr(1, "R6");
        put_word(32'h01020304, "R6");
        chk(word_addr === 9'd1, "R6 addr held", word_addr, 1);
        for (int i = 0; i < 4; i++) step(0, 0, 0, 0, 1, 8'h00, "R6 readback");

        // R9 priorities
        step(1, 0, 0, 0, 0, 8'h01, "R9");
        set_addr(40, "R9");
        step(0, 0, 0, 1, 0, 8'h10, "R9");
        step(0, 1, 0, 1, 0, 8'h30, "R9 addr beats window");
        put_word(32'h00000000, "R9");
        step(0, 0, 0, 1, 1, 8'h77, "R9 write beats read");
        step(0, 0, 0, 1, 1, 8'h66, "R9");
        step(0, 0, 0, 1, 1, 8'h55, "R9");
        step(0, 0, 0, 1, 1, 8'h44, "R9");

        // stream of patterned words
        set_addr(200, "R4");
        lfsr = 32'h1ACE_B00C;
        for (int i = 0; i < 40; i++) begin
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            put_word(lfsr, "R4 stream");
        end

        // R10 fetch sweep
        a0 = 200;
        for (int i = 0; i < 40; i++) begin
            fetch_addr = 9'(a0 + i);
            #0.5;
            chk(fetch_data === mem_m[a0 + i], "R10 sweep", fetch_data, mem_m[a0 + i]);
        end

        done = 1;
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule